// File: doc/BRIEF.md
# Dual-Output PWM Timebase with Per-Event Action Coding

This block generates two pulse-width-modulated outputs from one shared 16-bit time-base counter. The counter advances on a clock enable produced by a two-stage prescaler. One stage divides by a power of two. The other divides by one or by an even step up to fourteen. The counter can count up, count down, count up and then down, or stand still. Software programs the counting mode, both divider selects, a period and two compare values. It may also write the counter itself.

Each output has its own action register. The register holds a 2-bit code for each of six events: the counter at zero, the counter at the period, and the counter matching compare A or compare B, split by counting direction. The code tells the output to hold, go low, go high or invert. When several events land on the same counter step, a fixed priority picks one. This lets one block produce edge-aligned pulses, centre-aligned pulses and complementary patterns.

Access is through a simple strobed bus with a 5-bit byte address and 16-bit data. Reads return data one clock after the strobe, and a counter read gives the live count.

Top module: `duo_pwm_gen`

## Requirements
- R1: After reset both outputs are low, the counter reads 0, the period, compare and action registers read 0, and the control register reads 0x0003 (frozen, both dividers at 1).
- R2: A write strobe stores data at byte addresses control 0x00, counter 0x08, period 0x0A, compare A 0x12, compare B 0x14, action A 0x16 and action B 0x18. A read strobe returns the addressed value on the read data port one clock later. Control keeps only bits 12:7 and 1:0. The action registers keep only bits 11:0. Unstored bits and unmapped addresses read 0.
- R3: The counter steps once every D clocks, where D = 2^P × E. P is control bits 12:10. E is 1 when control bits 9:7 are 0, and twice that field otherwise. Any write to the control register restarts the prescaler, so the first step comes D clocks after that write.
- R4: In mode 0 (control bits 1:0) the counter counts up and goes from the period value to 0, so one cycle lasts period+1 steps.
- R5: In mode 1 the counter counts down and reloads the period value on the step after it reaches 0.
- R6: In mode 2 the counter counts up to the period and then down to 0, repeating, so one cycle lasts 2×period steps. The direction in force when the counter is at the period is up.
- R7: In mode 3 the counter and both outputs hold their values.
- R8: A write to the counter address loads that value, and counting continues from it.
- R9: On each counter step the action register decides the output. Bits 1:0 apply at zero, bits 3:2 at the period, bits 5:4 at compare A while counting up, bits 7:6 at compare A while counting down, bits 9:8 at compare B while up, and bits 11:10 at compare B while down. Code 0 holds the output, 1 drives it low, 2 drives it high and 3 inverts it. The output changes at the clock edge on which the event's counter value is present.
- R10: When several events with non-zero codes coincide on one step, zero wins over period, period over compare A, and compare A over compare B.
- R11: A compare event coded for one direction has no effect while the counter moves in the other direction. Up mode counts as always up and down mode as always down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one clock after the read strobe |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The hardest situations to reach are steps on which two events meet: a compare set to 0 or to the period, and the up-down turn where the period step still counts as upward. Directed configurations place compare values exactly on those points. Each one then measures output duty over whole cycles, so a wrong priority or a wrong direction flag shows up as a different count of high samples. Random configurations with short periods and small dividers follow. They shift the phase of every event against the prescaler, and a bench model compares both outputs on every clock.

// File: rtl/duo_pwm_pkg.sv
package duo_pwm_pkg;

  localparam int unsigned BUS_AW   = 5;
  localparam int unsigned BUS_DW   = 16;
  localparam int unsigned ACT_W    = 12;

  // control field positions (decoded by the prescaler and the counter)
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned EVEN_LSB = 7;
  localparam int unsigned POW_LSB  = 10;

  localparam logic [BUS_AW-1:0] ADR_CTRL = 5'h00;
  localparam logic [BUS_AW-1:0] ADR_CNT  = 5'h08;
  localparam logic [BUS_AW-1:0] ADR_PRD  = 5'h0A;
  localparam logic [BUS_AW-1:0] ADR_CMPA = 5'h12;
  localparam logic [BUS_AW-1:0] ADR_CMPB = 5'h14;
  localparam logic [BUS_AW-1:0] ADR_ACTA = 5'h16;
  localparam logic [BUS_AW-1:0] ADR_ACTB = 5'h18;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

endpackage

// File: rtl/duo_pwm_regs.sv
module duo_pwm_regs
  import duo_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  input  logic [CNT_W-1:0]     cnt,
  output logic [BUS_DW-1:0]    bus_rdata,
  output cnt_mode_e            mode,
  output logic [SEL_W-1:0]     sel_pow,
  output logic [SEL_W-1:0]     sel_even,
  output logic [CNT_W-1:0]     prd,
  output logic [CNT_W-1:0]     cmp_a,
  output logic [CNT_W-1:0]     cmp_b,
  output logic [ACT_W-1:0]     act_a,
  output logic [ACT_W-1:0]     act_b,
  output logic                 ctrl_wr,
  output logic                 cnt_wr
);

  logic [1:0]        mode_q, mode_d;
  logic [SEL_W-1:0]  pow_q, pow_d, even_q, even_d;
  logic [CNT_W-1:0]  prd_q, prd_d, cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic [ACT_W-1:0]  acta_q, acta_d, actb_q, actb_d;
  logic [BUS_DW-1:0] rd_q, rd_d, ctrl_rb;

  assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
  assign cnt_wr  = bus_wr && (bus_addr == ADR_CNT);

  always_comb begin
    ctrl_rb = '0;
    ctrl_rb[MODE_LSB +: 2]     = mode_q;
    ctrl_rb[EVEN_LSB +: SEL_W] = even_q;
    ctrl_rb[POW_LSB  +: SEL_W] = pow_q;
  end

  always_comb begin
    mode_d = mode_q;
    pow_d  = pow_q;
    even_d = even_q;
    prd_d  = prd_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    acta_d = acta_q;
    actb_d = actb_q;
    if (bus_wr) begin
      case (bus_addr)
        ADR_CTRL: begin
          mode_d = bus_wdata[MODE_LSB +: 2];
          even_d = bus_wdata[EVEN_LSB +: SEL_W];
          pow_d  = bus_wdata[POW_LSB  +: SEL_W];
        end
        ADR_PRD:  prd_d  = bus_wdata[CNT_W-1:0];
        ADR_CMPA: cmpa_d = bus_wdata[CNT_W-1:0];
        ADR_CMPB: cmpb_d = bus_wdata[CNT_W-1:0];
        ADR_ACTA: acta_d = bus_wdata[ACT_W-1:0];
        ADR_ACTB: actb_d = bus_wdata[ACT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL: rd_d = ctrl_rb;
        ADR_CNT:  rd_d = BUS_DW'(cnt);
        ADR_PRD:  rd_d = BUS_DW'(prd_q);
        ADR_CMPA: rd_d = BUS_DW'(cmpa_q);
        ADR_CMPB: rd_d = BUS_DW'(cmpb_q);
        ADR_ACTA: rd_d = BUS_DW'(acta_q);
        ADR_ACTB: rd_d = BUS_DW'(actb_q);
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HOLD;
      pow_q  <= '0;
      even_q <= '0;
      prd_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      acta_q <= '0;
      actb_q <= '0;
      rd_q   <= '0;
    end else begin
      mode_q <= mode_d;
      pow_q  <= pow_d;
      even_q <= even_d;
      prd_q  <= prd_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      acta_q <= acta_d;
      actb_q <= actb_d;
      rd_q   <= rd_d;
    end
  end

  assign mode      = cnt_mode_e'(mode_q);
  assign sel_pow   = pow_q;
  assign sel_even  = even_q;
  assign prd       = prd_q;
  assign cmp_a     = cmpa_q;
  assign cmp_b     = cmpb_q;
  assign act_a     = acta_q;
  assign act_b     = actb_q;
  assign bus_rdata = rd_q;

endmodule

// File: rtl/duo_pwm_prescale.sv
module duo_pwm_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel_pow,
  input  logic [SEL_W-1:0] sel_even,
  output logic             tick
);

  localparam int unsigned EVEN_W = SEL_W + 1;
  localparam int unsigned DIV_W  = EVEN_W + (1 << SEL_W) - 1;
  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

  logic [EVEN_W-1:0] even_div;
  logic [DIV_W-1:0]  total, last, pre_q, pre_d;

  always_comb begin
    even_div = (sel_even == '0) ? EVEN_W'(1) : {sel_even, 1'b0};
    total    = DIV_W'(even_div) << sel_pow;
    last     = total - ONE_D;
  end

  assign tick = (pre_q == last);

  always_comb begin
    if (restart || tick) pre_d = '0;
    else                 pre_d = pre_q + ONE_D;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/duo_pwm_counter.sv
module duo_pwm_counter
  import duo_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up
);

  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    case (mode)
      MODE_UP:   dir_up = 1'b1;
      MODE_DOWN: dir_up = 1'b0;
      default:   dir_up = dir_q;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      case (mode)
        MODE_UP:   cnt_d = (cnt_q == prd) ? '0 : cnt_q + ONE_C;
        MODE_DOWN: cnt_d = (cnt_q == '0) ? prd : cnt_q - ONE_C;
        MODE_UPDN: begin
          if (dir_q) begin
            if (cnt_q >= prd) begin
              dir_d = 1'b0;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE_C;
            end else begin
              cnt_d = cnt_q + ONE_C;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = 1'b1;
              cnt_d = (prd == '0) ? '0 : ONE_C;
            end else begin
              cnt_d = cnt_q - ONE_C;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/duo_pwm_action.sv
module duo_pwm_action
  import duo_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [ACT_W-1:0] act,
  output logic             out
);

  localparam int unsigned N_EV = ACT_W / 2;

  // event order is the priority order, lowest index wins
  logic [N_EV-1:0] ev;
  act_e            sel;
  logic            out_q, out_d;

  always_comb begin
    ev[0] = (cnt == '0);
    ev[1] = (cnt == prd);
    ev[2] = (cnt == cmp_a) &&  dir_up;
    ev[3] = (cnt == cmp_a) && !dir_up;
    ev[4] = (cnt == cmp_b) &&  dir_up;
    ev[5] = (cnt == cmp_b) && !dir_up;
  end

  always_comb begin
    sel = ACT_NONE;
    if (step) begin
      for (int i = N_EV - 1; i >= 0; i--) begin
        if (ev[i] && (act[2*i +: 2] != 2'd0)) sel = act_e'(act[2*i +: 2]);
      end
    end
  end

  always_comb begin
    case (sel)
      ACT_CLR: out_d = 1'b0;
      ACT_SET: out_d = 1'b1;
      ACT_TGL: out_d = ~out_q;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out = out_q;

endmodule

// File: rtl/duo_pwm_gen.sv
module duo_pwm_gen
  import duo_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int unsigned N_OUT = 2;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;

  cnt_mode_e         mode;
  logic [SEL_W-1:0]  sel_pow, sel_even;
  logic [CNT_W-1:0]  prd_q, cmp_a, cmp_b, cnt, cnt_load_val;
  logic [ACT_W-1:0]  act_a, act_b;
  logic              ctrl_wr, cnt_load, tick, step, dir_up;
  logic [ACT_W-1:0]  act_cfg [N_OUT];
  logic [N_OUT-1:0]  pwm_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  duo_pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt),
    .bus_rdata(bus_rdata),
    .mode     (mode),
    .sel_pow  (sel_pow),
    .sel_even (sel_even),
    .prd      (prd_q),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .act_a    (act_a),
    .act_b    (act_b),
    .ctrl_wr  (ctrl_wr),
    .cnt_wr   (cnt_load)
  );

  duo_pwm_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (ctrl_wr),
    .sel_pow (sel_pow),
    .sel_even(sel_even),
    .tick    (tick)
  );

  assign step         = tick && (mode != MODE_HOLD);
  assign cnt_load_val = bus_wdata[CNT_W-1:0];

  duo_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step    (step),
    .mode    (mode),
    .prd     (prd_q),
    .load    (cnt_load),
    .load_val(cnt_load_val),
    .cnt     (cnt),
    .dir_up  (dir_up)
  );

  assign act_cfg[0] = act_a;
  assign act_cfg[1] = act_b;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    duo_pwm_action #(.CNT_W(CNT_W)) u_act (
      .clk   (clk),
      .rst_n (rst_int_n),
      .step  (step),
      .cnt   (cnt),
      .dir_up(dir_up),
      .prd   (prd_q),
      .cmp_a (cmp_a),
      .cmp_b (cmp_b),
      .act   (act_cfg[g]),
      .out   (pwm_q[g])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

endmodule

// File: rtl/duo_pwm_chk.sv
module duo_pwm_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic             pwm_a,
  input logic             pwm_b
);

  // R3: no counter movement without a prescaler tick
  a_r3_no_step_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  // R4: up mode returns to zero after the period value
  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd0 && cnt == prd && !load) |=> (cnt == '0));

  // R5: down mode reloads the period after zero
  a_r5_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd1 && cnt == '0 && !load) |=> (cnt == $past(prd)));

  // R7: frozen mode holds counter and outputs
  a_r7_hold_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !load) |=> $stable(cnt));

  a_r7_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> ($stable(pwm_a) && $stable(pwm_b)));

  // R8: a counter write lands on the next clock
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R9: outputs only change on a counter step
  a_r9_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

endmodule

bind duo_pwm_gen duo_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .tick    (tick),
  .mode    (mode),
  .cnt     (cnt),
  .prd     (prd_q),
  .load    (cnt_load),
  .load_val(cnt_load_val),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b)
);

// File: tb/sim_duo_pwm_gen.sv
`timescale 1ns/1ps
module sim_duo_pwm_gen;

  logic        clk, rst_n, bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        pwm_a, pwm_b;

  int checks = 0;
  int fails  = 0;
  logic chk_on = 1'b0;

  duo_pwm_gen u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- bench model built from the requirements ----------------
  logic [15:0] m_ctrl, m_prd, m_cmpa, m_cmpb, m_acta, m_actb, m_cnt, m_rdata;
  logic        m_dir, m_a, m_b;
  int          m_pre;

  function automatic int f_total(input logic [15:0] c);
    int e;
    e = (c[9:7] == 3'd0) ? 1 : 2 * int'(c[9:7]);
    return e << c[12:10];
  endfunction

  function automatic logic f_act(input logic cur, input logic [15:0] q,
                                 input logic [15:0] c, input logic up);
    logic [1:0] code;
    code = 2'd0;
    if      (c == m_cmpb && !up && q[11:10] != 0) code = q[11:10];
    if      (c == m_cmpb &&  up && q[9:8]   != 0) code = q[9:8];
    if      (c == m_cmpa && !up && q[7:6]   != 0) code = q[7:6];
    if      (c == m_cmpa &&  up && q[5:4]   != 0) code = q[5:4];
    if      (c == m_prd         && q[3:2]   != 0) code = q[3:2];
    if      (c == 16'd0         && q[1:0]   != 0) code = q[1:0];
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [15:0] f_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_ctrl;
      5'h08:   return m_cnt;
      5'h0A:   return m_prd;
      5'h12:   return m_cmpa;
      5'h14:   return m_cmpb;
      5'h16:   return m_acta;
      5'h18:   return m_actb;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic tk, stp, de;
    logic [1:0] md;
    logic [15:0] nc;
    logic nd;
    if (!rst_n) begin
      m_ctrl = 16'h0003; m_prd = 0; m_cmpa = 0; m_cmpb = 0; m_acta = 0; m_actb = 0;
      m_cnt = 0; m_rdata = 0; m_dir = 1'b1; m_a = 1'b0; m_b = 1'b0; m_pre = 0;
    end else begin
      tk  = (m_pre == f_total(m_ctrl) - 1);
      md  = m_ctrl[1:0];
      stp = tk && (md != 2'd3);
      de  = (md == 2'd0) ? 1'b1 : (md == 2'd1) ? 1'b0 : m_dir;
      if (stp) begin
        m_a = f_act(m_a, m_acta, m_cnt, de);
        m_b = f_act(m_b, m_actb, m_cnt, de);
      end
      if (bus_rd) m_rdata = f_read(bus_addr);
      nc = m_cnt; nd = m_dir;
      if (bus_wr && bus_addr == 5'h08) nc = bus_wdata;
      else if (stp) begin
        case (md)
          2'd0: nc = (m_cnt == m_prd) ? 16'd0 : m_cnt + 16'd1;
          2'd1: nc = (m_cnt == 0) ? m_prd : m_cnt - 16'd1;
          default: begin
            if (m_dir) begin
              if (m_cnt >= m_prd) begin nd = 1'b0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
              else nc = m_cnt + 16'd1;
            end else begin
              if (m_cnt == 0) begin nd = 1'b1; nc = (m_prd == 0) ? 16'd0 : 16'd1; end
              else nc = m_cnt - 16'd1;
            end
          end
        endcase
      end
      m_cnt = nc; m_dir = nd;
      if ((bus_wr && bus_addr == 5'h00) || tk) m_pre = 0;
      else m_pre = m_pre + 1;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_ctrl = bus_wdata & 16'h1F83;
          5'h0A: m_prd  = bus_wdata;
          5'h12: m_cmpa = bus_wdata;
          5'h14: m_cmpb = bus_wdata;
          5'h16: m_acta = bus_wdata & 16'h0FFF;
          5'h18: m_actb = bus_wdata & 16'h0FFF;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (pwm_a !== m_a || pwm_b !== m_b) begin
        fails++;
        $display("FAIL R9/R10 random: pwm a,b=%b%b expected %b%b at %0t", pwm_a, pwm_b, m_a, m_b, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_cfg(input logic [15:0] c, p, ca, cb, qa, qb, output int ha, output int hb);
    wr(5'h00, 16'h0003);
    wr(5'h0A, p); wr(5'h12, ca); wr(5'h14, cb);
    wr(5'h16, qa); wr(5'h18, qb);
    wr(5'h08, 16'h0);
    wr(5'h00, c);
    repeat (30) @(negedge clk);
    ha = 0; hb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ha += int'(pwm_a); hb += int'(pwm_b);
    end
  endtask

  // counter read a fixed number of clocks after a restarting control write
  task automatic step_count(input logic [15:0] c, input int k, output logic [15:0] v);
    wr(5'h00, c | 16'h0003);
    wr(5'h08, 16'h0);
    wr(5'h00, c);
    repeat (k - 2) @(negedge clk);
    rd(5'h08, v);
  endtask

  initial begin : watchdog
    #800us;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v, v2;
    int ha, hb;
    logic sa, sb, stable;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 pwm_a", int'(pwm_a), 0);
    check("R1 pwm_b", int'(pwm_b), 0);
    rd(5'h00, v); check("R1 ctrl", int'(v), 16'h0003);
    rd(5'h08, v); check("R1 cnt", int'(v), 0);
    rd(5'h0A, v); check("R1 prd", int'(v), 0);

    // R2 register map and readback
    wr(5'h0A, 16'h1234); rd(5'h0A, v); check("R2 prd", int'(v), 16'h1234);
    wr(5'h12, 16'hBEEF); rd(5'h12, v); check("R2 cmpa", int'(v), 16'hBEEF);
    wr(5'h14, 16'h5A5A); rd(5'h14, v); check("R2 cmpb", int'(v), 16'h5A5A);
    wr(5'h16, 16'hFFFF); rd(5'h16, v); check("R2 acta masked", int'(v), 16'h0FFF);
    wr(5'h18, 16'h0000); rd(5'h18, v); check("R2 actb", int'(v), 0);
    wr(5'h00, 16'hFFFF); rd(5'h00, v); check("R2 ctrl masked", int'(v), 16'h1F83);
    rd(5'h02, v); check("R2 unmapped", int'(v), 0);
    wr(5'h16, 16'h0); wr(5'h12, 16'h0); wr(5'h14, 16'h0);

    // R8 counter load, then continue counting by 1 per clock
    wr(5'h0A, 16'd1000);
    wr(5'h00, 16'h0003);
    wr(5'h08, 16'd300); rd(5'h08, v); check("R8 load", int'(v), 300);
    wr(5'h00, 16'h0000);
    repeat (8) @(negedge clk);
    rd(5'h08, v); check("R8 continue", int'(v), 309);

    // R3 prescaler: read at clock k after restart gives floor((k-1)/D)
    step_count(16'h0500, 81, v); check("R3 div 2x4", int'(v), 10);
    step_count(16'h0380, 71, v); check("R3 div 1x14", int'(v), 5);
    step_count(16'h0980, 73, v); check("R3 div 4x6", int'(v), 3);

    // R4 / R9 up mode, period 9: set at zero, clear / toggle at compare
    run_cfg(16'h0000, 16'd9, 16'd4, 16'd7, 16'h0012, 16'h0302, ha, hb);
    check("R4 up duty A", ha, 16);
    check("R9 toggle duty B", hb, 28);

    // R5 / R11 down mode: clear on A-down; B's A-up toggle ignored
    run_cfg(16'h0001, 16'd9, 16'd4, 16'd0, 16'h0042, 16'h0032, ha, hb);
    check("R5 down duty A", ha, 24);
    check("R11 up code ignored in down", hb, 40);

    // R6 up-down, period 5 (10 clocks per cycle)
    run_cfg(16'h0002, 16'd5, 16'd2, 16'd3, 16'h0012, 16'h0600, ha, hb);
    check("R6 updown duty A", ha, 8);
    check("R6 R11 centred duty B", hb, 16);

    // R7 freeze
    wr(5'h00, 16'h0003);
    rd(5'h08, v);
    sa = pwm_a; sb = pwm_b; stable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_a !== sa || pwm_b !== sb) stable = 1'b0;
    end
    rd(5'h08, v2);
    check("R7 cnt held", int'(v2), int'(v));
    check("R7 outputs held", int'(stable), 1);

    // R10 priorities, up mode period 9
    run_cfg(16'h0000, 16'd9, 16'd0, 16'd3, 16'h0012, 16'h0000, ha, hb);
    check("R10 zero over A", ha, 40);
    run_cfg(16'h0000, 16'd9, 16'd9, 16'd3, 16'h0000, 16'h0018, ha, hb);
    check("R10 period over A", hb, 40);
    run_cfg(16'h0000, 16'd9, 16'd5, 16'd5, 16'h0120, 16'h0000, ha, hb);
    check("R10 A over B", ha, 40);

    // random configurations against the bench model (R4 R5 R6 R9 R10 R11)
    for (int it = 0; it < 16; it++) begin
      logic [15:0] p, c;
      chk_on = 1'b0;
      p = 16'($urandom_range(0, 12));
      c = 16'($urandom_range(0, 3)) | (16'($urandom_range(0, 1)) << 10) |
          (16'($urandom_range(0, 2)) << 7);
      wr(5'h0A, p);
      wr(5'h12, 16'($urandom_range(0, int'(p) + 1)));
      wr(5'h14, 16'($urandom_range(0, int'(p) + 1)));
      wr(5'h16, 16'($urandom_range(0, 4095)));
      wr(5'h18, 16'($urandom_range(0, 4095)));
      wr(5'h08, 16'h0);
      wr(5'h00, c);
      chk_on = 1'b1;
      repeat (150) @(negedge clk);
      rd(5'h08, v);
      check("R4 R5 R6 random count", int'(v), int'(m_rdata));
    end
    chk_on = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule